// File: doc/BRIEF.md
# Time-Redundant Majority Execution Unit

This block protects one shared datapath operation against transient upsets by running it three times in a row, not by building three copies of it. A request supplies two operands with a start pulse. The unit latches the operands and presents them to the wrapped single-cycle function on three consecutive cycles. It keeps the first two results in holding registers. When the third result arrives, it forms a bit-wise majority of all three and publishes the voted word with a one-cycle done strobe.

The wrapped function sits outside the unit. The unit drives the function's operands, an issue strobe and a pass number. It samples the function's result in the same cycle. Two flags come with each vote. The first shows that at least one pass disagreed with the voted word. The second shows that no two passes agreed on the full word, in which case the vote cannot be trusted. The unit accepts a new request only after the vote is complete, so each request occupies it for five cycles.

Top module: `tmr_seq_exec`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, fn_valid_o, mismatch_o and untrusted_o are 0 and result_o is 0.
- R2: A start_i seen in idle at a clock edge latches opa_i/opb_i. fn_valid_o is then high for the next three cycles with fn_pass_o equal to 1, 2 and 3 in that order, and fn_opa_o/fn_opb_o carry the latched operands.
- R3: Changes on opa_i/opb_i during a request do not affect fn_opa_o/fn_opb_o or the voted result.
- R4: done_o is high for exactly one cycle, the cycle after pass 3. The unit is idle (busy_o low) in the cycle that follows.
- R5: result_o at done equals the bit-wise majority (a&b)|(a&c)|(b&c) of the results of passes 1, 2 and 3.
- R6: mismatch_o at done is 1 when any of the three pass results differs from the voted word, and 0 when all three agree.
- R7: untrusted_o at done is 1 exactly when all three pass results differ pairwise on the full word. untrusted_o implies mismatch_o.
- R8: busy_o is high from the cycle after acceptance through the done cycle. start_i while busy_o is high is ignored and starts no extra pass.
- R9: result_o, mismatch_o and untrusted_o hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| busy_o | output | 1 | Request in progress |
| fn_valid_o | output | 1 | Wrapped function is being exercised this cycle |
| fn_pass_o | output | 2 | Pass number 1..3, 0 when no pass runs |
| fn_opa_o | output | WIDTH | Latched first operand to the function |
| fn_opb_o | output | WIDTH | Latched second operand to the function |
| fn_res_i | input | WIDTH | Function result for the current pass |
| result_o | output | WIDTH | Voted result |
| done_o | output | 1 | One-cycle strobe: vote complete |
| mismatch_o | output | 1 | Some pass disagreed with the vote |
| untrusted_o | output | 1 | No two passes agreed |

## Verification
The hardest situation to reach from the ports is a fault that hits only one of the three passes while the other two stay clean. This needs a corruption aligned to a single cycle of a request. The bench models the wrapped function itself and XORs a per-pass mask into its result according to fn_pass_o. This lets each pass be corrupted in turn, and also pairs of passes with equal masks (a wrong majority) or with distinct masks (no two copies agree). The same requests toggle start_i and scramble the operand inputs while the unit is busy, to show that neither has any effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int PASS_W = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN1,
      ST_RUN2,
      ST_RUN3,
      ST_VOTE
   } tmr_state_e;
endpackage

// File: rtl/tmr_seq_ctrl.sv
module tmr_seq_ctrl
   import tmr_pkg::*;
#(
   parameter int PW = PASS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          accept_o,
   output logic          busy_o,
   output logic          issue_o,
   output logic [PW-1:0] pass_o,
   output logic          cap1_o,
   output logic          cap2_o,
   output logic          cap3_o,
   output logic          done_o
);
   tmr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_RUN1;
         ST_RUN1: state_d = ST_RUN2;
         ST_RUN2: state_d = ST_RUN3;
         ST_RUN3: state_d = ST_VOTE;
         ST_VOTE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign accept_o = (state_q == ST_IDLE) && start_i;
   assign busy_o   = (state_q != ST_IDLE);
   assign cap1_o   = (state_q == ST_RUN1);
   assign cap2_o   = (state_q == ST_RUN2);
   assign cap3_o   = (state_q == ST_RUN3);
   assign issue_o  = cap1_o | cap2_o | cap3_o;
   assign done_o   = (state_q == ST_VOTE);

   always_comb begin
      pass_o = '0;
      if (cap1_o) pass_o = PW'(1);
      if (cap2_o) pass_o = PW'(2);
      if (cap3_o) pass_o = PW'(3);
   end
endmodule

// File: rtl/tmr_bit_voter.sv
module tmr_bit_voter #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] copy_a_i,
   input  logic [WIDTH-1:0] copy_b_i,
   input  logic [WIDTH-1:0] copy_c_i,
   output logic [WIDTH-1:0] voted_o,
   output logic             mismatch_o,
   output logic             untrusted_o
);
   logic [WIDTH-1:0] bit_dis;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign voted_o[i] = (copy_a_i[i] & copy_b_i[i]) |
                          (copy_a_i[i] & copy_c_i[i]) |
                          (copy_b_i[i] & copy_c_i[i]);
      assign bit_dis[i] = (copy_a_i[i] ^ copy_b_i[i]) |
                          (copy_a_i[i] ^ copy_c_i[i]);
   end

   assign mismatch_o  = |bit_dis;
   assign untrusted_o = (copy_a_i != copy_b_i) &&
                        (copy_a_i != copy_c_i) &&
                        (copy_b_i != copy_c_i);
endmodule

// File: rtl/tmr_seq_exec.sv
module tmr_seq_exec
   import tmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WIDTH-1:0]  opa_i,
   input  logic [WIDTH-1:0]  opb_i,
   output logic              busy_o,
   output logic              fn_valid_o,
   output logic [1:0]        fn_pass_o,
   output logic [WIDTH-1:0]  fn_opa_o,
   output logic [WIDTH-1:0]  fn_opb_o,
   input  logic [WIDTH-1:0]  fn_res_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              done_o,
   output logic              mismatch_o,
   output logic              untrusted_o
);
   localparam int PW = PASS_W;

   if (WIDTH < 1) begin : g_bad_width
      $error("tmr_seq_exec: WIDTH must be at least 1");
   end
   if (PW != 2) begin : g_bad_pass
      $error("tmr_seq_exec: pass field must be 2 bits wide");
   end

   logic accept, cap1, cap2, cap3;
   logic [WIDTH-1:0] opa_q, opb_q, hold1_q, hold2_q;
   logic [WIDTH-1:0] voted, result_q;
   logic mism, untr, mism_q, untr_q;

   tmr_seq_ctrl #(.PW(PW)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy_o),
      .issue_o  (fn_valid_o),
      .pass_o   (fn_pass_o),
      .cap1_o   (cap1),
      .cap2_o   (cap2),
      .cap3_o   (cap3),
      .done_o   (done_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q <= '0;
         opb_q <= '0;
      end else if (accept) begin
         opa_q <= opa_i;
         opb_q <= opb_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold1_q <= '0;
         hold2_q <= '0;
      end else begin
         if (cap1) hold1_q <= fn_res_i;
         if (cap2) hold2_q <= fn_res_i;
      end
   end

   tmr_bit_voter #(.WIDTH(WIDTH)) voter_i (
      .copy_a_i    (hold1_q),
      .copy_b_i    (hold2_q),
      .copy_c_i    (fn_res_i),
      .voted_o     (voted),
      .mismatch_o  (mism),
      .untrusted_o (untr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         mism_q   <= 1'b0;
         untr_q   <= 1'b0;
      end else if (cap3) begin
         result_q <= voted;
         mism_q   <= mism;
         untr_q   <= untr;
      end
   end

   assign fn_opa_o    = opa_q;
   assign fn_opb_o    = opb_q;
   assign result_o    = result_q;
   assign mismatch_o  = mism_q;
   assign untrusted_o = untr_q;
endmodule

// File: rtl/tmr_seq_exec_chk.sv
module tmr_seq_exec_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             fn_valid_o,
   input logic [1:0]       fn_pass_o,
   input logic [WIDTH-1:0] fn_opa_o,
   input logic [WIDTH-1:0] fn_opb_o,
   input logic [WIDTH-1:0] fn_res_i,
   input logic [WIDTH-1:0] result_o,
   input logic             done_o,
   input logic             mismatch_o,
   input logic             untrusted_o
);
   function automatic logic [WIDTH-1:0] maj3(logic [WIDTH-1:0] a, b, c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   assert_start_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (fn_valid_o && fn_pass_o == 2'd1));
   assert_pass1_to_2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_pass_o == 2'd1) |=> (fn_pass_o == 2'd2));
   assert_pass2_to_3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_pass_o == 2'd2) |=> (fn_pass_o == 2'd3));
   assert_operand_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_pass_o == 2'd1 || fn_pass_o == 2'd2) |=>
         ($stable(fn_opa_o) && $stable(fn_opb_o)));
   assert_done_after_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_pass_o == 2'd3) |=> done_o);
   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));
   assert_majority_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o == maj3($past(fn_res_i, 3), $past(fn_res_i, 2),
                                    $past(fn_res_i, 1))));
   assert_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (mismatch_o == (($past(fn_res_i, 3) != result_o) ||
                                 ($past(fn_res_i, 2) != result_o) ||
                                 ($past(fn_res_i, 1) != result_o))));
   assert_untrusted_implies_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      untrusted_o |-> mismatch_o);
   assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);
   assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(mismatch_o) && $stable(untrusted_o)));
endmodule

bind tmr_seq_exec tmr_seq_exec_chk #(.WIDTH(WIDTH)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .fn_valid_o  (fn_valid_o),
   .fn_pass_o   (fn_pass_o),
   .fn_opa_o    (fn_opa_o),
   .fn_opb_o    (fn_opb_o),
   .fn_res_i    (fn_res_i),
   .result_o    (result_o),
   .done_o      (done_o),
   .mismatch_o  (mismatch_o),
   .untrusted_o (untrusted_o)
);

// File: tb/tmr_seq_exec_tb_top.sv
module tmr_seq_exec_tb_top;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [W-1:0] opa_i = '0, opb_i = '0;
   logic busy_o, fn_valid_o, done_o, mismatch_o, untrusted_o;
   logic [1:0] fn_pass_o;
   logic [W-1:0] fn_opa_o, fn_opb_o, fn_res_i, result_o;
   logic [W-1:0] m1 = '0, m2 = '0, m3 = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit test_done = 1'b0;
   logic [W+1:0] sb_q[$];

   always #2.5 clk = ~clk;

   // Bench model of the wrapped function: sum, with a per-pass fault mask.
   always_comb begin
      fn_res_i = fn_opa_o + fn_opb_o;
      case (fn_pass_o)
         2'd1: fn_res_i = fn_res_i ^ m1;
         2'd2: fn_res_i = fn_res_i ^ m2;
         2'd3: fn_res_i = fn_res_i ^ m3;
         default: ;
      endcase
   end

   tmr_seq_exec #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
      .busy_o(busy_o), .fn_valid_o(fn_valid_o), .fn_pass_o(fn_pass_o),
      .fn_opa_o(fn_opa_o), .fn_opb_o(fn_opb_o), .fn_res_i(fn_res_i),
      .result_o(result_o), .done_o(done_o), .mismatch_o(mismatch_o),
      .untrusted_o(untrusted_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Driver: one request, with ignored start pulses and scrambled operands.
   task automatic run_op(input logic [W-1:0] a, b, f1, f2, f3);
      logic [W-1:0] g, c1, c2, c3, v;
      logic mm, ut;
      g  = a + b;
      c1 = g ^ f1; c2 = g ^ f2; c3 = g ^ f3;
      v  = (c1 & c2) | (c1 & c3) | (c2 & c3);
      mm = (c1 != v) || (c2 != v) || (c3 != v);
      ut = (c1 != c2) && (c1 != c3) && (c2 != c3);
      @(negedge clk);
      m1 = f1; m2 = f2; m3 = f3;
      opa_i = a; opb_i = b; start_i = 1'b1;
      sb_q.push_back({ut, mm, v});
      for (int p = 1; p <= 3; p++) begin
         @(negedge clk);
         chk(fn_valid_o && busy_o && fn_pass_o == 2'(p), "R2", "pass number",
             {30'd0, fn_pass_o}, p);
         chk(fn_opa_o == a && fn_opb_o == b, "R3", "operands held",
             {16'd0, fn_opa_o}, {16'd0, a});
         chk(busy_o, "R8", "busy during pass", {31'd0, busy_o}, 1);
         opa_i = ~a; opb_i = a ^ 16'h5A5A;   // scramble, start still high
      end
      @(negedge clk);
      chk(done_o && busy_o, "R4", "done after pass 3", {31'd0, done_o}, 1);
      @(negedge clk);
      start_i = 1'b0;
      chk(!done_o && !busy_o && !fn_valid_o, "R8", "no extra run from busy start",
          {29'd0, done_o, busy_o, fn_valid_o}, 0);
      chk(result_o == v, "R9", "result held after done", {16'd0, result_o}, {16'd0, v});
   endtask

   // Monitor: pops the expected vote whenever done is seen.
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected done", 1, 0);
         end else begin
            logic [W+1:0] e;
            e = sb_q.pop_front();
            chk(result_o == e[W-1:0], "R5", "voted result",
                {16'd0, result_o}, {16'd0, e[W-1:0]});
            chk(mismatch_o == e[W], "R6", "mismatch flag",
                {31'd0, mismatch_o}, {31'd0, e[W]});
            chk(untrusted_o == e[W+1], "R7", "untrusted flag",
                {31'd0, untrusted_o}, {31'd0, e[W+1]});
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !fn_valid_o && !mismatch_o && !untrusted_o && result_o == '0,
          "R1", "state in reset", {16'd0, result_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && result_o == '0, "R1", "state after reset",
          {30'd0, busy_o, done_o}, 0);
      // clean runs
      run_op(16'h1234, 16'h0101, '0, '0, '0);
      run_op(16'hFFFF, 16'h0001, '0, '0, '0);
      run_op(16'hA5A5, 16'h5A5A, '0, '0, '0);
      // single-pass faults, each pass in turn
      run_op(16'h0F0F, 16'h0003, 16'h0001, '0, '0);
      run_op(16'h0F0F, 16'h0003, '0, 16'h8000, '0);
      run_op(16'h0F0F, 16'h0003, '0, '0, 16'hFFFF);
      // two passes with equal corruption: majority follows the wrong pair
      run_op(16'h1000, 16'h0234, 16'h0010, '0, 16'h0010);
      // two passes, different bits: bit vote correct, no full-word pair
      run_op(16'h2222, 16'h1111, 16'h0001, 16'h0002, '0);
      // three distinct corruptions
      run_op(16'h0000, 16'h0000, 16'h0001, 16'h0002, 16'h0004);
      // clean run clears the flags
      run_op(16'h7777, 16'h0001, '0, '0, '0);
      repeat (2) @(negedge clk);
      chk(sb_q.size() == 0, "R4", "all votes delivered", sb_q.size(), 0);
      test_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!test_done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R4 watchdog expired: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule